// File: doc/BRIEF.md
# Vector Element Address Sequencer

This block turns a single vector memory operation into a stream of per-element effective addresses. On a start pulse it captures a base value, a signed 16-bit displacement, a shift amount, an access width in bytes, a vector length and an addressing mode. It then offers one 64-bit address per element over a valid/ready handshake, in element order, each tagged with the sequential element number. It pulses a completion flag once the last address has been accepted. It does no memory or register file access.

Three ways of forming addresses are supported. Element stride steps by the displacement itself. Unit stride steps by the access width after a fixed displacement. The shifted mode scales the displacement by the access width and by a bit-reversed element number, then shifts the result left. That mode supplies the butterfly reordering used by radix-2 FFT data loads.

The controller is a four-state machine:
- IDLE waits for start. From IDLE, start goes to FIN when the length is zero, to ERR when the length is illegal for bit-reversed ordering, and to ISSUE otherwise.
- ISSUE offers addresses. It stays in ISSUE until the last element is accepted, then goes to FIN.
- FIN pulses done for one cycle and returns to IDLE.
- ERR pulses done and err for one cycle and returns to IDLE.

Top module: `vec_agen`

## Requirements
- R1: The operation inputs are sampled only in the cycle where `start` is high while the block is idle. A `start` pulse given while an operation is running has no effect on the addresses it produces.
- R2: Element stride is `mode`=1. Address i is base + sext(disp) * i, and the access width is not used. With base 0x10, disp 24 and length 2, the addresses are 0x10 and 0x28.
- R3: If `mode`=1 is given with `base_scalar`=0 or with disp equal to 0, the block uses unit stride instead. `mode`=3 is also treated as unit stride.
- R4: Unit stride is `mode`=0. Address i is base + sext(disp) + acc_size * i.
- R5: Shifted bit-reversed mode is `mode`=2. Let j be i bit-reversed over log2(vlen) bits. Address i is base + ((sext(disp) * acc_size * j) << shamt). For length 4, base 0x10, disp 1, size 4 and shift 0, the addresses are 0x10, 0x18, 0x14, 0x1C.
- R6: When `base_zero` is high, the base is taken as 0 and `base_val` is ignored.
- R7: Exactly vlen addresses are issued, one per accepted handshake. `elem_idx` carries the sequential number i, from 0 upward. `done` is high for one cycle, in the cycle after the last handshake, and `addr_valid` is low in that cycle.
- R8: A length of 0 issues no address. `done` is high in the cycle right after the start cycle.
- R9: In mode 2, a length that is not a power of two issues no address. `err` and `done` are then both high for one cycle, in the cycle after start.
- R10: Address arithmetic is 64-bit and wraps modulo 2^64, and the displacement is sign-extended.
- R11: While `addr_valid` is high and `addr_ready` is low, `addr_valid`, `addr` and `elem_idx` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| mode | input | 2 | 0 unit, 1 element stride, 2 shifted bit-reversed, 3 unit |
| base_scalar | input | 1 | Base operand is a scalar (gates element stride) |
| base_zero | input | 1 | Base register number is zero: base is 0 |
| base_val | input | 64 | Base register contents |
| disp | input | 16 | Signed displacement |
| shamt | input | 5 | Left shift applied in mode 2 |
| acc_size | input | 4 | Access width in bytes |
| vlen | input | 8 | Number of elements |
| addr_ready | input | 1 | Consumer accepts the offered address |
| addr_valid | output | 1 | An address is offered |
| addr | output | 64 | Effective address of the current element |
| elem_idx | output | 8 | Sequential element number of the current address |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse: illegal length for mode 2 |

## Verification
Several properties are checked on every cycle. The held-offer rule of R11 covers valid, element number and address. The element number always stays below the captured length. Done never coincides with a valid offer, and err never appears without done. Whether the address values follow the formulas of each mode, including fallback, bit-reversed order, the zero base and wrap-around, can only be shown by the bench scenarios. The same holds for exact element counts, the done timing after a zero length or an error, and start pulses ignored while busy.

// File: rtl/agen_pkg.sv
package agen_pkg;
    typedef enum logic [1:0] {
        MODE_UNIT = 2'd0,
        MODE_ELEM = 2'd1,
        MODE_SHBR = 2'd2,
        MODE_RSVD = 2'd3
    } agen_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FIN   = 2'd2,
        ST_ERR   = 2'd3
    } agen_state_e;
endpackage

// File: rtl/agen_setup.sv
module agen_setup
    import agen_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16,
    parameter int VL_W   = 8,
    parameter int LG_W   = $clog2(VL_W)
) (
    input  logic [1:0]        mode_in,
    input  logic              base_scalar,
    input  logic              base_zero,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [DISP_W-1:0] disp,
    input  logic [VL_W-1:0]   vl,
    output agen_mode_e        eff_mode,
    output logic [ADDR_W-1:0] eff_base,
    output logic              vl_pow2,
    output logic [LG_W-1:0]   vl_log2
);
    // resolve mode: element stride needs scalar base and nonzero displacement
    always_comb begin
        unique case (mode_in)
            2'd1:    eff_mode = (base_scalar && (disp != '0)) ? MODE_ELEM : MODE_UNIT;
            2'd2:    eff_mode = MODE_SHBR;
            default: eff_mode = MODE_UNIT;
        endcase
    end

    assign eff_base = base_zero ? '0 : base_val;
    assign vl_pow2  = (vl != '0) && ((vl & (vl - 1'b1)) == '0);

    // position of lowest set bit equals log2 for a power of two
    always_comb begin
        vl_log2 = '0;
        for (int b = VL_W - 1; b >= 0; b--) begin
            if (vl[b]) vl_log2 = LG_W'(b);
        end
    end
endmodule

// File: rtl/agen_bitrev.sv
module agen_bitrev #(
    parameter int IDX_W = 8,
    parameter int LG_W  = $clog2(IDX_W)
) (
    input  logic [IDX_W-1:0] idx_in,
    input  logic [LG_W-1:0]  nbits,
    output logic [IDX_W-1:0] idx_rev
);
    always_comb begin
        idx_rev = '0;
        for (int b = 0; b < IDX_W; b++) begin
            if (b < int'(nbits)) begin
                idx_rev[b] = idx_in[int'(nbits) - 1 - b];
            end
        end
    end
endmodule

// File: rtl/agen_calc.sv
module agen_calc
    import agen_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16,
    parameter int SH_W   = 5,
    parameter int SZ_W   = 4,
    parameter int VL_W   = 8,
    parameter int LG_W   = $clog2(VL_W)
) (
    input  agen_mode_e        mode,
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    input  logic [SH_W-1:0]   shamt,
    input  logic [SZ_W-1:0]   size,
    input  logic [VL_W-1:0]   idx,
    input  logic [LG_W-1:0]   lg,
    output logic [ADDR_W-1:0] addr
);
    logic [VL_W-1:0]   idx_rev;
    logic [ADDR_W-1:0] sdisp;
    logic [ADDR_W-1:0] idx_w;
    logic [ADDR_W-1:0] rev_w;
    logic [ADDR_W-1:0] size_w;
    logic [ADDR_W-1:0] offset;

    agen_bitrev #(.IDX_W(VL_W), .LG_W(LG_W)) u_rev (
        .idx_in (idx),
        .nbits  (lg),
        .idx_rev(idx_rev)
    );

    assign sdisp  = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    assign idx_w  = {{(ADDR_W-VL_W){1'b0}}, idx};
    assign rev_w  = {{(ADDR_W-VL_W){1'b0}}, idx_rev};
    assign size_w = {{(ADDR_W-SZ_W){1'b0}}, size};

    always_comb begin
        unique case (mode)
            MODE_ELEM: offset = sdisp * idx_w;
            MODE_SHBR: offset = (sdisp * size_w * rev_w) << shamt;
            default:   offset = sdisp + size_w * idx_w;
        endcase
    end

    assign addr = base + offset;
endmodule

// File: rtl/agen_ctrl.sv
module agen_ctrl
    import agen_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16,
    parameter int SH_W   = 5,
    parameter int SZ_W   = 4,
    parameter int VL_W   = 8,
    parameter int LG_W   = $clog2(VL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  agen_mode_e        in_mode,
    input  logic [ADDR_W-1:0] in_base,
    input  logic [DISP_W-1:0] in_disp,
    input  logic [SH_W-1:0]   in_shamt,
    input  logic [SZ_W-1:0]   in_size,
    input  logic [VL_W-1:0]   in_vl,
    input  logic              in_pow2,
    input  logic [LG_W-1:0]   in_lg,
    input  logic              ready,
    output agen_mode_e        op_mode,
    output logic [ADDR_W-1:0] op_base,
    output logic [DISP_W-1:0] op_disp,
    output logic [SH_W-1:0]   op_shamt,
    output logic [SZ_W-1:0]   op_size,
    output logic [LG_W-1:0]   op_lg,
    output logic [VL_W-1:0]   idx,
    output logic              valid,
    output logic              done,
    output logic              err
);
    agen_state_e    state, state_nx;
    logic [VL_W-1:0] op_vl;
    logic           capture;
    logic           last_acc;

    assign capture  = (state == ST_IDLE) && start;
    assign last_acc = (state == ST_ISSUE) && ready && (idx == op_vl - 1'b1);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (in_vl == '0)                         state_nx = ST_FIN;
                    else if (in_mode == MODE_SHBR && !in_pow2) state_nx = ST_ERR;
                    else                                     state_nx = ST_ISSUE;
                end
            end
            ST_ISSUE: if (last_acc) state_nx = ST_FIN;
            ST_FIN:   state_nx = ST_IDLE;
            ST_ERR:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register with operand capture and element counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            op_vl    <= '0;
            op_mode  <= MODE_UNIT;
            op_base  <= '0;
            op_disp  <= '0;
            op_shamt <= '0;
            op_size  <= '0;
            op_lg    <= '0;
        end else begin
            state <= state_nx;
            if (capture) begin
                idx      <= '0;
                op_vl    <= in_vl;
                op_mode  <= in_mode;
                op_base  <= in_base;
                op_disp  <= in_disp;
                op_shamt <= in_shamt;
                op_size  <= in_size;
                op_lg    <= in_lg;
            end else if (state == ST_ISSUE && ready && !last_acc) begin
                idx <= idx + 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        valid = 1'b0;
        done  = 1'b0;
        err   = 1'b0;
        unique case (state)
            ST_ISSUE: valid = 1'b1;
            ST_FIN:   done  = 1'b1;
            ST_ERR: begin
                done = 1'b1;
                err  = 1'b1;
            end
            default: ;
        endcase
    end

    // R11: an offer not taken stays with the same element
    p_hold_offer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(idx)))
        else $error("offer dropped without handshake");

    // R7: element number stays inside the captured length
    p_idx_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (idx < op_vl))
        else $error("element number out of range");

    // R7: completion never overlaps an offer
    p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !valid)
        else $error("done while offering");

    // R9: error only as part of completion, and only in mode 2
    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && op_mode == MODE_SHBR))
        else $error("err without done or outside mode 2");

    // R8: a zero length never produces an offer
    p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (op_vl != '0))
        else $error("offer for zero length");
endmodule

// File: rtl/vec_agen.sv
module vec_agen
    import agen_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16,
    parameter int SH_W   = 5,
    parameter int SZ_W   = 4,
    parameter int VL_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic              base_scalar,
    input  logic              base_zero,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [DISP_W-1:0] disp,
    input  logic [SH_W-1:0]   shamt,
    input  logic [SZ_W-1:0]   acc_size,
    input  logic [VL_W-1:0]   vlen,
    input  logic              addr_ready,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    output logic [VL_W-1:0]   elem_idx,
    output logic              done,
    output logic              err
);
    localparam int LG_W = $clog2(VL_W);

    agen_mode_e        s_mode, op_mode;
    logic [ADDR_W-1:0] s_base, op_base;
    logic              s_pow2;
    logic [LG_W-1:0]   s_lg, op_lg;
    logic [DISP_W-1:0] op_disp;
    logic [SH_W-1:0]   op_shamt;
    logic [SZ_W-1:0]   op_size;

    agen_setup #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .VL_W(VL_W), .LG_W(LG_W)) u_setup (
        .mode_in    (mode),
        .base_scalar(base_scalar),
        .base_zero  (base_zero),
        .base_val   (base_val),
        .disp       (disp),
        .vl         (vlen),
        .eff_mode   (s_mode),
        .eff_base   (s_base),
        .vl_pow2    (s_pow2),
        .vl_log2    (s_lg)
    );

    agen_ctrl #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SH_W(SH_W), .SZ_W(SZ_W),
                .VL_W(VL_W), .LG_W(LG_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .in_mode (s_mode),
        .in_base (s_base),
        .in_disp (disp),
        .in_shamt(shamt),
        .in_size (acc_size),
        .in_vl   (vlen),
        .in_pow2 (s_pow2),
        .in_lg   (s_lg),
        .ready   (addr_ready),
        .op_mode (op_mode),
        .op_base (op_base),
        .op_disp (op_disp),
        .op_shamt(op_shamt),
        .op_size (op_size),
        .op_lg   (op_lg),
        .idx     (elem_idx),
        .valid   (addr_valid),
        .done    (done),
        .err     (err)
    );

    agen_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SH_W(SH_W), .SZ_W(SZ_W),
                .VL_W(VL_W), .LG_W(LG_W)) u_calc (
        .mode (op_mode),
        .base (op_base),
        .disp (op_disp),
        .shamt(op_shamt),
        .size (op_size),
        .idx  (elem_idx),
        .lg   (op_lg),
        .addr (addr)
    );

    // R11: the offered address itself is held under backpressure
    p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready) |=> $stable(addr))
        else $error("address changed under backpressure");
endmodule

// File: tb/tb_vec_agen.sv
module tb_vec_agen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = '0;
    logic        base_scalar = 1'b1;
    logic        base_zero = 1'b0;
    logic [63:0] base_val = '0;
    logic [15:0] disp = '0;
    logic [4:0]  shamt = '0;
    logic [3:0]  acc_size = '0;
    logic [7:0]  vlen = '0;
    logic        addr_ready = 1'b1;
    logic        addr_valid;
    logic [63:0] addr;
    logic [7:0]  elem_idx;
    logic        done;
    logic        err;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [63:0] got [0:255];
    int got_n;
    int wait_cyc;
    logic saw_err;

    vec_agen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .base_scalar(base_scalar), .base_zero(base_zero), .base_val(base_val),
        .disp(disp), .shamt(shamt), .acc_size(acc_size), .vlen(vlen),
        .addr_ready(addr_ready), .addr_valid(addr_valid), .addr(addr),
        .elem_idx(elem_idx), .done(done), .err(err)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog R7 actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference address from the stated formulas
    function automatic logic [63:0] ref_addr(input logic [1:0] m, input logic sc, input logic bz,
            input logic [63:0] b, input logic [15:0] d, input logic [4:0] sh,
            input logic [3:0] sz, input logic [7:0] vl, input int i);
        logic [63:0] bb, sd, j;
        int k;
        bb = bz ? 64'd0 : b;
        sd = {{48{d[15]}}, d};
        if (m == 2'd2) begin
            k = 0;
            while ((1 << k) < vl) k++;
            j = '0;
            for (int t = 0; t < k; t++) if (((i >> t) & 1) != 0) j[k-1-t] = 1'b1;
            return bb + ((sd * {60'd0, sz} * j) << sh);
        end else if (m == 2'd1 && sc && d != 16'd0) begin
            return bb + sd * 64'(i);
        end else begin
            return bb + sd + {60'd0, sz} * 64'(i);
        end
    endfunction

    // run one operation with ready held high, checking every offer
    task automatic run_op(input string req, input logic [1:0] m, input logic sc, input logic bz,
            input logic [63:0] b, input logic [15:0] d, input logic [4:0] sh,
            input logic [3:0] sz, input logic [7:0] vl);
        @(negedge clk);
        mode = m; base_scalar = sc; base_zero = bz; base_val = b; disp = d;
        shamt = sh; acc_size = sz; vlen = vl; addr_ready = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_n = 0; wait_cyc = 0; saw_err = 1'b0;
        for (int g = 0; g < 600; g++) begin
            if (addr_valid) begin
                check({req, " addr"}, addr, ref_addr(m, sc, bz, b, d, sh, sz, vl, got_n));
                check("R7 elem_idx", {56'd0, elem_idx}, 64'(got_n));
                got[got_n] = addr;
                got_n++;
            end
            if (done) begin
                saw_err = err;
                break;
            end
            wait_cyc++;
            @(negedge clk);
        end
        @(negedge clk);
        check("R7 done one cycle", {63'd0, done}, 64'd0);
    endtask

    task automatic t_reset;
        check("R7 reset valid", {63'd0, addr_valid}, 64'd0);
        check("R7 reset done", {63'd0, done}, 64'd0);
        check("R9 reset err", {63'd0, err}, 64'd0);
    endtask

    task automatic t_elem_stride;
        run_op("R2", 2'd1, 1'b1, 1'b0, 64'h10, 16'd24, 5'd0, 4'd4, 8'd2);
        check("R2 count", 64'(got_n), 64'd2);
        check("R2 elem0", got[0], 64'h10);
        check("R2 elem1", got[1], 64'h28);
        run_op("R2", 2'd1, 1'b1, 1'b0, 64'h1000, 16'd40, 5'd3, 4'd8, 8'd5);
        check("R2 size unused", got[4], 64'h1000 + 64'd160);
    endtask

    task automatic t_unit_stride;
        run_op("R4", 2'd0, 1'b1, 1'b0, 64'h10, 16'd8, 5'd7, 4'd4, 8'd2);
        check("R4 elem0", got[0], 64'h18);
        check("R4 elem1", got[1], 64'h1C);
        run_op("R4", 2'd0, 1'b0, 1'b0, 64'h200, 16'd0, 5'd0, 4'd8, 8'd7);
        check("R7 count", 64'(got_n), 64'd7);
        check("R4 elem6", got[6], 64'h230);
    endtask

    task automatic t_fallback;
        run_op("R3", 2'd1, 1'b1, 1'b0, 64'h40, 16'd0, 5'd0, 4'd4, 8'd3);
        check("R3 zero disp", got[2], 64'h48);
        run_op("R3", 2'd1, 1'b0, 1'b0, 64'h40, 16'd24, 5'd0, 4'd2, 8'd3);
        check("R3 vector base", got[2], 64'h40 + 64'd24 + 64'd4);
        run_op("R3", 2'd3, 1'b1, 1'b0, 64'h40, 16'd24, 5'd0, 4'd2, 8'd2);
        check("R3 mode3", got[1], 64'h40 + 64'd24 + 64'd2);
    endtask

    task automatic t_shifted;
        run_op("R5", 2'd2, 1'b1, 1'b0, 64'h10, 16'd1, 5'd0, 4'd4, 8'd4);
        check("R5 count", 64'(got_n), 64'd4);
        check("R5 elem0", got[0], 64'h10);
        check("R5 elem1", got[1], 64'h18);
        check("R5 elem2", got[2], 64'h14);
        check("R5 elem3", got[3], 64'h1C);
        run_op("R5", 2'd2, 1'b1, 1'b0, 64'h100, 16'd1, 5'd2, 4'd8, 8'd8);
        check("R5 shift elem1", got[1], 64'h100 + (64'd32 << 2));
        run_op("R5", 2'd2, 1'b1, 1'b0, 64'h80, 16'd3, 5'd1, 4'd2, 8'd1);
        check("R5 len1", got[0], 64'h80);
    endtask

    task automatic t_zero_base;
        run_op("R6", 2'd1, 1'b1, 1'b1, 64'hDEAD_0000, 16'd16, 5'd0, 4'd4, 8'd3);
        check("R6 elem0", got[0], 64'd0);
        check("R6 elem2", got[2], 64'd32);
    endtask

    task automatic t_wrap;
        run_op("R10", 2'd1, 1'b1, 1'b0, 64'd0, 16'hFFF8, 5'd0, 4'd4, 8'd3);
        check("R10 neg elem1", got[1], 64'hFFFF_FFFF_FFFF_FFF8);
        check("R10 neg elem2", got[2], 64'hFFFF_FFFF_FFFF_FFF0);
        run_op("R10", 2'd0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFC, 16'd0, 5'd0, 4'd4, 8'd2);
        check("R10 wrap", got[1], 64'd0);
    endtask

    task automatic t_zero_len;
        run_op("R8", 2'd0, 1'b1, 1'b0, 64'h10, 16'd4, 5'd0, 4'd4, 8'd0);
        check("R8 no addr", 64'(got_n), 64'd0);
        check("R8 done next cycle", 64'(wait_cyc), 64'd0);
        check("R8 no err", {63'd0, saw_err}, 64'd0);
    endtask

    task automatic t_bad_len;
        run_op("R9", 2'd2, 1'b1, 1'b0, 64'h10, 16'd1, 5'd0, 4'd4, 8'd6);
        check("R9 no addr", 64'(got_n), 64'd0);
        check("R9 err", {63'd0, saw_err}, 64'd1);
        check("R9 timing", 64'(wait_cyc), 64'd0);
        run_op("R9", 2'd0, 1'b1, 1'b0, 64'h10, 16'd1, 5'd0, 4'd4, 8'd6);
        check("R9 other mode ok", {63'd0, saw_err}, 64'd0);
    endtask

    // backpressure hold and start ignored while busy
    task automatic t_hold_and_busy;
        logic [63:0] a0;
        @(negedge clk);
        mode = 2'd1; base_scalar = 1'b1; base_zero = 1'b0; base_val = 64'h500;
        disp = 16'd12; shamt = '0; acc_size = 4'd4; vlen = 8'd3;
        addr_ready = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        a0 = addr;
        check("R11 valid", {63'd0, addr_valid}, 64'd1);
        @(negedge clk);
        base_val = 64'h9000; disp = 16'd1; vlen = 8'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R11 held valid", {63'd0, addr_valid}, 64'd1);
        check("R11 held addr", addr, a0);
        check("R11 held idx", {56'd0, elem_idx}, 64'd0);
        addr_ready = 1'b1;
        got_n = 0;
        for (int g = 0; g < 50; g++) begin
            if (addr_valid) begin
                got[got_n] = addr;
                got_n++;
            end
            if (done) break;
            @(negedge clk);
        end
        check("R1 count unaffected", 64'(got_n), 64'd3);
        check("R1 elem2 unaffected", got[2], 64'h500 + 64'd24);
        @(negedge clk);
        check("R1 idle after", {63'd0, addr_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_elem_stride();
        t_unit_stride();
        t_fallback();
        t_shifted();
        t_zero_base();
        t_wrap();
        t_zero_len();
        t_bad_len();
        t_hold_and_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule